// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

The controller groups general purpose pins into ports of eight. A simple 32-bit register bus reaches all of them. Each port can drive its pins in one of four ways: not at all, push-pull, pulling low only, or pulling high only. Each pin has its own pull-up control. Each pin can also report a rising or a falling edge as an interrupt event. Software can raise a pin's interrupt directly through a force bit. Each port drives one interrupt line, which combines its eight pins.

A global control word sits at address 0. It holds a clock-request bit and an input-synchronizer select bit. It also reports the number of ports and a core version number. Port `p` has its register window at byte address `p*0x30`. Global pin `n` belongs to port `n>>3` and to interrupt line `irq[n>>3]`.

A read is requested with a one-cycle `bus_rd` pulse. The data returns on the next cycle together with `bus_rvalid`. A write takes effect on the clock edge where `bus_wr` is high.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After synchronous reset, every pin is released (`pad_oe` = 0, `pad_out` = 0) with its pull-up enabled. Every `irq` line is 0 and `clk_req` is 0.
- R2: The word at address 0x00 has these fields:
  - bit 0: clock request, read/write, driven on `clk_req`
  - bit 1: input synchronizer select, read/write
  - bits 8:2: the CORE_VERSION parameter, read-only
  - bits 15:9: NPORTS, read-only
  - all other bits: 0
  Writes to the read-only fields have no effect.
- R3: The offsets within port `p`'s window at `p*0x30` are:
  - input level: 0x04
  - output data: 0x08
  - drive mode: 0x0C
  - pull-up disable: 0x10
  - event: 0x14
  - interrupt enable: 0x18
  - force: 0x1C
  - edge select: 0x20
  Read data appears one cycle after `bus_rd` with `bus_rvalid`. Unmapped or misaligned addresses and unused upper bits read 0.
- R4: Pin `k` of a port takes its drive mode from bits [2k+1:2k] of the mode register. The outputs for each code are:

  | Code | Mode | `pad_oe` | `pad_out` |
  |------|------|----------|-----------|
  | 00 | input | 0 | 0 |
  | 01 | push-pull | 1 | data bit |
  | 10 | pull-low-only | 1 when the data bit is 0 | 0 |
  | 11 | pull-high-only | 1 when the data bit is 1 | 1 only while driving |

  A released pin always shows `pad_out` = 0.
- R5: A 1 in the pull-up disable register turns that pin's `pad_pu_en` off. The output follows the register on the cycle after the write.
- R6: With synchronizer select set, pins pass through two flops before they reach the input-level register and the edge detector. With it clear, the raw pin value is used in the same cycle. Writes to the input-level register have no effect.
- R7: An edge-select bit of 1 means only a rising edge on that pin sets its event bit. An edge-select bit of 0 means only a falling edge does.
- R8: Writing 1 to an event bit clears it. If an edge on that pin lands in the same cycle as the clear, the event bit stays set.
- R9: `irq[p]` is the OR over port `p`'s pins of (event OR force) AND enable.
- R10: Pin `n` is controlled by port `n>>3` and raises only `irq[n>>3]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read request, one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | NPORTS*8 | Pin levels from the pads |
| pad_out | output | NPORTS*8 | Pin drive value |
| pad_oe | output | NPORTS*8 | Pin drive enable |
| pad_pu_en | output | NPORTS*8 | Pull-up enable per pin |
| irq | output | NPORTS | One interrupt line per port |
| clk_req | output | 1 | Clock request bit from the control word |

## Verification
A stuck or misdecoded configuration bit shows up on `pad_oe`, `pad_out` or `pad_pu_en` on the cycle after the write. It also shows up in the next register read, one cycle after the request. A wrong event bit reaches the port's `irq` line in the same cycle it is stored. A synchronizer fault changes the depth of the input path, so the input level and the event would appear earlier or later than the two-cycle delay. Pins are checked across ports, so a misplaced window base raises the wrong `irq` line or reads back in the wrong window.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    // Pins per port. The address map and field packing depend on this being 8.
    localparam int PORT_W    = 8;
    // Byte spacing between consecutive port windows.
    localparam int WIN_BYTES = 'h30;

    // Byte offsets within one port window.
    localparam logic [5:0] OFF_LEVEL = 6'h04;
    localparam logic [5:0] OFF_DOUT  = 6'h08;
    localparam logic [5:0] OFF_MODE  = 6'h0C;
    localparam logic [5:0] OFF_PULL  = 6'h10;
    localparam logic [5:0] OFF_EVT   = 6'h14;
    localparam logic [5:0] OFF_IEN   = 6'h18;
    localparam logic [5:0] OFF_FRC   = 6'h1C;
    localparam logic [5:0] OFF_EDGE  = 6'h20;

    typedef enum logic [1:0] {
        DRV_INPUT       = 2'b00,
        DRV_PUSH_PULL   = 2'b01,
        DRV_SINK_ONLY   = 2'b10,
        DRV_SOURCE_ONLY = 2'b11
    } drive_mode_e;

    typedef struct packed {
        logic out;
        logic oe;
    } pad_drive_t;

    // Layout of the global control word.
    typedef struct packed {
        logic [15:0] zero_hi;
        logic [6:0]  ports;
        logic [6:0]  version;
        logic        sync_sel;
        logic        clk_req;
    } ctrl_word_t;

    // Per-port writable state.
    typedef struct packed {
        logic [PORT_W-1:0]   dout;
        logic [2*PORT_W-1:0] mode;
        logic [PORT_W-1:0]   pull_dis;
        logic [PORT_W-1:0]   ien;
        logic [PORT_W-1:0]   frc;
        logic [PORT_W-1:0]   edge_rise;
    } port_cfg_t;

    // Drive value for one pin. A released pin always presents out = 0.
    function automatic pad_drive_t drive_pin(input drive_mode_e m, input logic d);
        pad_drive_t r;
        unique case (m)
            DRV_PUSH_PULL:   r = '{out: d,    oe: 1'b1};
            DRV_SINK_ONLY:   r = '{out: 1'b0, oe: ~d};
            DRV_SOURCE_ONLY: r = '{out: d,    oe: d};
            default:         r = '{out: 1'b0, oe: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpx_in_sync.sv
module gpx_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sync_sel,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    localparam int STAGES = 2;

    logic [STAGES-1:0][W-1:0] chain_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= '0;
        end else begin
            chain_q[0] <= pad_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
            prev_q <= level;
        end
    end

    assign level = sync_sel ? chain_q[STAGES-1] : pad_in;
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;

endmodule

// File: rtl/gpx_pad_drive.sv
module gpx_pad_drive
    import gpx_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [2*W-1:0] mode,
    input  logic [W-1:0]   dout,
    input  logic [W-1:0]   pull_dis,
    output logic [W-1:0]   pad_out,
    output logic [W-1:0]   pad_oe,
    output logic [W-1:0]   pad_pu_en
);
    for (genvar k = 0; k < W; k++) begin : g_pin
        pad_drive_t drv;
        assign drv          = drive_pin(drive_mode_e'(mode[2*k +: 2]), dout[k]);
        assign pad_out[k]   = drv.out;
        assign pad_oe[k]    = drv.oe;
        assign pad_pu_en[k] = ~pull_dis[k];
    end

endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [5:0]        off,
    input  logic [15:0]       wdata,
    input  logic [PORT_W-1:0] level,
    input  logic [PORT_W-1:0] rise,
    input  logic [PORT_W-1:0] fall,
    output logic [31:0]       rdata,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu_en,
    output logic              irq
);
    port_cfg_t         cfg_q;
    logic [PORT_W-1:0] evt_q;
    logic [PORT_W-1:0] evt_d;
    logic [PORT_W-1:0] evt_clr;
    logic [PORT_W-1:0] edge_hit;

    // A pin's event is set only by the edge its edge-select bit picks.
    assign edge_hit = (cfg_q.edge_rise & rise) | (~cfg_q.edge_rise & fall);
    assign evt_clr  = (wr && off == OFF_EVT) ? wdata[PORT_W-1:0] : '0;
    // An edge in the same cycle as a clear keeps the event set.
    assign evt_d    = (evt_q & ~evt_clr) | edge_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
            if (wr) begin
                unique case (off)
                    OFF_DOUT: cfg_q.dout      <= wdata[PORT_W-1:0];
                    OFF_MODE: cfg_q.mode      <= wdata[2*PORT_W-1:0];
                    OFF_PULL: cfg_q.pull_dis  <= wdata[PORT_W-1:0];
                    OFF_IEN:  cfg_q.ien       <= wdata[PORT_W-1:0];
                    OFF_FRC:  cfg_q.frc       <= wdata[PORT_W-1:0];
                    OFF_EDGE: cfg_q.edge_rise <= wdata[PORT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (off)
            OFF_LEVEL: rdata[PORT_W-1:0]   = level;
            OFF_DOUT:  rdata[PORT_W-1:0]   = cfg_q.dout;
            OFF_MODE:  rdata[2*PORT_W-1:0] = cfg_q.mode;
            OFF_PULL:  rdata[PORT_W-1:0]   = cfg_q.pull_dis;
            OFF_EVT:   rdata[PORT_W-1:0]   = evt_q;
            OFF_IEN:   rdata[PORT_W-1:0]   = cfg_q.ien;
            OFF_FRC:   rdata[PORT_W-1:0]   = cfg_q.frc;
            OFF_EDGE:  rdata[PORT_W-1:0]   = cfg_q.edge_rise;
            default: ;
        endcase
    end

    assign irq = |((evt_q | cfg_q.frc) & cfg_q.ien);

    gpx_pad_drive #(.W(PORT_W)) i_drive (
        .mode      (cfg_q.mode),
        .dout      (cfg_q.dout),
        .pull_dis  (cfg_q.pull_dis),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu_en (pad_pu_en)
    );

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpx_pkg::*;
#(
    parameter int          NPORTS       = 3,
    parameter logic [6:0]  CORE_VERSION = 7'd3,
    parameter int          ADDR_W       = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       bus_rvalid,
    input  logic [NPORTS*PORT_W-1:0]   pad_in,
    output logic [NPORTS*PORT_W-1:0]   pad_out,
    output logic [NPORTS*PORT_W-1:0]   pad_oe,
    output logic [NPORTS*PORT_W-1:0]   pad_pu_en,
    output logic [NPORTS-1:0]          irq,
    output logic                       clk_req
);
    localparam int NPIN = NPORTS * PORT_W;

    logic                    clk_req_q;
    logic                    sync_sel_q;
    logic                    ctrl_hit;
    ctrl_word_t              ctrl_word;
    logic [NPORTS-1:0][31:0] port_rd;
    logic [31:0]             rd_mux;
    logic                    unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:16];
    assign ctrl_hit        = (bus_addr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_req_q  <= 1'b0;
            sync_sel_q <= 1'b0;
        end else if (bus_wr && ctrl_hit) begin
            clk_req_q  <= bus_wdata[0];
            sync_sel_q <= bus_wdata[1];
        end
    end

    assign ctrl_word = '{zero_hi:  '0,
                         ports:    7'(NPORTS),
                         version:  CORE_VERSION,
                         sync_sel: sync_sel_q,
                         clk_req:  clk_req_q};
    assign clk_req = clk_req_q;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int BASE = p * WIN_BYTES;

        logic [ADDR_W-1:0] rel;
        logic              hit;
        logic [31:0]       rd;
        logic [PORT_W-1:0] level;
        logic [PORT_W-1:0] rise;
        logic [PORT_W-1:0] fall;

        assign rel = bus_addr - ADDR_W'(BASE);
        assign hit = (bus_addr >= ADDR_W'(BASE)) && (rel < ADDR_W'(WIN_BYTES));

        gpx_in_sync #(.W(PORT_W)) i_sync (
            .clk      (clk),
            .rst      (rst),
            .sync_sel (sync_sel_q),
            .pad_in   (pad_in[p*PORT_W +: PORT_W]),
            .level    (level),
            .rise     (rise),
            .fall     (fall)
        );

        gpx_port i_port (
            .clk       (clk),
            .rst       (rst),
            .wr        (bus_wr && hit),
            .off       (rel[5:0]),
            .wdata     (bus_wdata[15:0]),
            .level     (level),
            .rise      (rise),
            .fall      (fall),
            .rdata     (rd),
            .pad_out   (pad_out[p*PORT_W +: PORT_W]),
            .pad_oe    (pad_oe[p*PORT_W +: PORT_W]),
            .pad_pu_en (pad_pu_en[p*PORT_W +: PORT_W]),
            .irq       (irq[p])
        );

        assign port_rd[p] = hit ? rd : '0;
    end

    always_comb begin
        rd_mux = ctrl_hit ? ctrl_word : '0;
        for (int p = 0; p < NPORTS; p++) begin
            rd_mux = rd_mux | port_rd[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int NPIN   = 24,
    parameter int NPORTS = 3,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        wdata_lo,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe,
    input logic [NPIN-1:0]   pad_pu_en,
    input logic [NPORTS-1:0] irq,
    input logic              clk_req
);
    // R1: first cycle out of reset is quiet
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq == '0 && pad_oe == '0 && pad_pu_en == '1 && !clk_req));

    // R3: read data returns exactly one cycle after the request
    a_r3_rvalid_follows_rd: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);
    a_r3_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

    // R3: misaligned addresses read zero
    a_r3_misaligned_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

    // R2: clock request bit follows a control write
    a_r2_clkreq_written: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == '0) |=> clk_req == $past(wdata_lo[0]));

    // R4: a released pin presents a low output value
    a_r4_released_low: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

    // R5: port 0 pull-ups follow a write to its pull-up disable register
    a_r5_pull_follows_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'('h10)) |=> pad_pu_en[7:0] == ~$past(wdata_lo));

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
    .NPIN   (NPIN),
    .NPORTS (NPORTS),
    .ADDR_W (ADDR_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .wdata_lo   (bus_wdata[7:0]),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_pu_en  (pad_pu_en),
    .irq        (irq),
    .clk_req    (clk_req)
);

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NPORTS     = 3;
    localparam int NPIN       = NPORTS * 8;
    localparam int ADDR_W     = 10;
    localparam logic [6:0] VER = 7'd3;
    localparam logic [31:0] CTRL_RO = (32'(NPORTS) << 9) | (32'(VER) << 2);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NPIN-1:0]   pad_in = '0;
    logic [NPIN-1:0]   pad_out;
    logic [NPIN-1:0]   pad_oe;
    logic [NPIN-1:0]   pad_pu_en;
    logic [NPORTS-1:0] irq;
    logic              clk_req;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_ctrl #(.NPORTS(NPORTS), .CORE_VERSION(VER), .ADDR_W(ADDR_W)) i_gpio_edge_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en),
        .irq(irq), .clk_req(clk_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: pushes the expected word, then issues the read.
    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares each returned word with the oldest expectation.
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R3: unexpected rvalid, actual %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        check("R1 pad_out", 32'(pad_out), 32'h0);
        check("R1 pad_pu_en", 32'(pad_pu_en), 32'h00FF_FFFF);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 clk_req", 32'(clk_req), 32'h0);
        bus_read(10'h000, CTRL_RO, "R1 ctrl reset");
        bus_read(10'h014, 32'h0, "R1 event reset");

        // R2 control word
        bus_write(10'h000, 32'hFFFF_FFFF);
        check("R2 clk_req set", 32'(clk_req), 32'h1);
        bus_read(10'h000, CTRL_RO | 32'h3, "R2 ctrl ro fields");
        bus_write(10'h000, 32'h2);
        check("R2 clk_req clear", 32'(clk_req), 32'h0);
        bus_read(10'h000, CTRL_RO | 32'h2, "R2 sync only");

        // R3 address map
        bus_read(10'h024, 32'h0, "R3 past window end");
        bus_read(10'h030, 32'h0, "R3 port1 offset 0");
        bus_read(10'h006, 32'h0, "R3 misaligned");
        bus_read(10'h090, 32'h0, "R3 beyond last port");
        bus_write(10'h03C, 32'hFFFF_FFFF);
        bus_read(10'h03C, 32'h0000_FFFF, "R3 mode upper bits zero");
        bus_write(10'h03C, 32'h0);

        // R4 drive modes on port 0 pins 0..3: 01,10,11,00
        bus_write(10'h00C, 32'h39);
        bus_write(10'h008, 32'h0F);
        check("R4 oe data=1", 32'(pad_oe[3:0]), 32'h5);
        check("R4 out data=1", 32'(pad_out[3:0]), 32'h5);
        bus_write(10'h008, 32'h00);
        check("R4 oe data=0", 32'(pad_oe[3:0]), 32'h3);
        check("R4 out data=0", 32'(pad_out[3:0]), 32'h0);
        bus_read(10'h008, 32'h0, "R4 dout readback");

        // R5 pull-up disable on port 2
        bus_write(10'h070, 32'h81);
        check("R5 pu_en port2", 32'(pad_pu_en[23:16]), 32'h7E);
        check("R5 pu_en others", 32'(pad_pu_en[15:0]), 32'hFFFF);
        bus_read(10'h070, 32'h81, "R5 pull readback");

        // R6 input sampling
        pad_in[7:0] = 8'hA5;
        idle(4);
        bus_read(10'h004, 32'hA5, "R6 level synced");
        bus_write(10'h004, 32'hFF);
        bus_read(10'h004, 32'hA5, "R6 level write ignored");
        bus_write(10'h000, 32'h0);
        pad_in[7:0] = 8'h3C;
        bus_read(10'h004, 32'h3C, "R6 level direct path");
        bus_write(10'h000, 32'h2);
        idle(4);

        // R7 and R10 on port 1
        bus_write(10'h050, 32'h01);
        bus_write(10'h048, 32'h03);
        pad_in[8] = 1'b1;
        idle(4);
        check("R10 irq1 only", 32'(irq), 32'h2);
        bus_read(10'h044, 32'h01, "R7 rising event");
        bus_write(10'h044, 32'h01);
        check("R8 clear drops irq", 32'(irq), 32'h0);
        pad_in[8] = 1'b0;
        idle(4);
        bus_read(10'h044, 32'h00, "R7 falling ignored on rising pin");
        pad_in[9] = 1'b1;
        idle(4);
        bus_read(10'h044, 32'h00, "R7 rising ignored on falling pin");
        pad_in[9] = 1'b0;
        idle(4);
        bus_read(10'h044, 32'h02, "R7 falling event");
        check("R7 irq1 from fall", 32'(irq), 32'h2);
        bus_write(10'h044, 32'hFF);

        // R8 clear colliding with a new edge on port 2, direct path
        bus_write(10'h000, 32'h0);
        bus_write(10'h080, 32'h01);
        bus_write(10'h078, 32'h01);
        pad_in[16] = 1'b1;
        idle(1);
        bus_read(10'h074, 32'h01, "R8 event set");
        pad_in[16] = 1'b0;
        idle(2);
        pad_in[16] = 1'b1;
        bus_write(10'h074, 32'h01);
        bus_read(10'h074, 32'h01, "R8 edge wins over clear");
        bus_write(10'h074, 32'h01);
        bus_read(10'h074, 32'h00, "R8 plain clear");
        check("R8 irq2 low", 32'(irq[2]), 32'h0);

        // R9 force and enable
        bus_write(10'h07C, 32'h02);
        check("R9 force masked", 32'(irq[2]), 32'h0);
        bus_write(10'h078, 32'h03);
        check("R9 force enabled", 32'(irq[2]), 32'h1);
        bus_write(10'h07C, 32'h00);
        check("R9 force removed", 32'(irq[2]), 32'h0);

        idle(3);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R3: missing read data, actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule